// File: doc/BRIEF.md
# Receive Destination Address Screen

This block sits at the head of an Ethernet receive path and decides, from the first six bytes of each incoming frame, whether the frame is wanted. Bytes arrive one per qualified cycle on `byteData` with `byteValid`. The first byte of a frame is marked by `byteSof`, and `frameEnd` marks the last byte of the frame.

The destination address is sorted into one of three classes. An all-ones address is broadcast. An address is hashed when its group bit is set or when the hash-everything mode is on; a 64-entry table is then indexed by a six-bit slice of a CRC-32 computed over the address. Every other address must equal the configured station address exactly. A frame that fails its class test is "missed". A missed frame is dropped unless promiscuous mode is on, in which case it is kept and still reports the miss so that it can be flagged in the receive status. The CRC is accumulated one byte per cycle, alongside the byte-by-byte station compare, so the decision is ready in the cycle after the sixth byte.

Top module: `rx_da_screen`

## Requirements
- R1: After reset, `decValid`, `accept` and `miss` are all 0.
- R2: The byte qualified with `byteSof` is address byte 0. `decValid` is 1 for exactly the one cycle after the edge that captures address byte 5. Bytes after byte 5 in the same frame do not change `decValid`, `accept` or `miss`.
- R3: A destination of six 0xFF bytes is broadcast, and its miss equals `bcastReject`.
- R4: For a non-broadcast address where bit 0 of byte 0 is 1 or `hashAll` is 1, the CRC register starts at 0xFFFFFFFF. Bits of each byte are taken LSB first. For each bit, the register shifts left by one and is XORed with 0x04C11DB7 when the old bit 31 XOR the data bit is 1. There is no final inversion. The index is CRC bits 31:26, and miss = NOT `hashTable[index]`.
- R5: Any other address misses unless every address byte k equals `stationAddr[8k+7:8k]`.
- R6: At a decision, `accept` = NOT miss OR `promiscEn`.
- R7: A `frameEnd` on any byte from byte 0 to byte 4 ends the frame early. In the next cycle, `decValid` is 1, `miss` is 1, and `accept` equals `promiscEn`.
- R8: `accept` and `miss` hold their decided values until the next `byteSof` byte. In the cycle after that byte, both read 0, unless that same byte also ends the frame.
- R9: Cycles with `byteValid` low neither advance the byte position nor affect the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| byteValid | input | 1 | Qualifies `byteData` |
| byteSof | input | 1 | Marks the first byte of a frame |
| frameEnd | input | 1 | Marks the last byte of a frame |
| byteData | input | 8 | Received byte |
| stationAddr | input | 48 | Station address, byte k at bits 8k+7:8k |
| hashTable | input | 64 | Group hash table, bit i is entry i |
| promiscEn | input | 1 | Keep missed frames |
| bcastReject | input | 1 | Miss broadcast frames |
| hashAll | input | 1 | Hash every non-broadcast address |
| decValid | output | 1 | One-cycle decision strobe |
| accept | output | 1 | Frame is kept (held) |
| miss | output | 1 | Frame failed its address test (held) |

## Verification
Random frames are drawn from five address kinds: the exact station address, the station address with one byte altered, random group addresses, broadcast, and random unicast with hash-everything on. Together these separate the three classes and the order in which they take priority. The hash table and mode bits are random, so the hash path is seen both hitting and missing. Idle gaps between bytes and payload bytes after the address show that only qualified address bytes count. Directed short frames, including a one-byte frame, exercise the early-end miss, and promiscuous runs show that a kept frame still reports its miss.

// File: rtl/rx_da_pkg.sv
package rx_da_pkg;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFFFFFF;

  typedef struct packed {
    logic start;
    logic take;
  } strobe_t;
endpackage

// File: rtl/rx_da_ctrl.sv
module rx_da_ctrl #(
  parameter int ADDR_BYTES = 6,
  localparam int IDXW = $clog2(ADDR_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  byteValid,
  input  logic                  byteSof,
  input  logic                  frameEnd,
  input  logic                  promiscEn,
  input  logic                  missNow,
  output rx_da_pkg::strobe_t    stb,
  output logic [IDXW-1:0]       byteIdx,
  output logic                  decValid,
  output logic                  acceptQ,
  output logic                  missQ
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(ADDR_BYTES - 1);

  logic [IDXW-1:0] cnt;
  logic active, isFirst, take, lastByte, shortEnd;

  always_comb begin
    isFirst  = byteValid && byteSof;
    take     = byteValid && (byteSof || active);
    byteIdx  = byteSof ? '0 : cnt;
    lastByte = take && (byteIdx == LAST_IDX);
    shortEnd = frameEnd && (active || isFirst) && !lastByte;
    stb.start = isFirst;
    stb.take  = take;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      active   <= 1'b0;
      decValid <= 1'b0;
      acceptQ  <= 1'b0;
      missQ    <= 1'b0;
    end else begin
      if (take) begin
        cnt    <= byteIdx + 1'b1;
        active <= (byteIdx != LAST_IDX);
      end
      if (shortEnd) active <= 1'b0;
      decValid <= lastByte || shortEnd;
      if (isFirst) begin
        acceptQ <= 1'b0;
        missQ   <= 1'b0;
      end
      if (lastByte) begin
        missQ   <= missNow;
        acceptQ <= !missNow || promiscEn;
      end else if (shortEnd) begin
        missQ   <= 1'b1;
        acceptQ <= promiscEn;
      end
    end
  end
endmodule

// File: rtl/rx_da_path.sv
module rx_da_path #(
  parameter int ADDR_BYTES = 6,
  parameter int DATA_W     = 8,
  parameter int HASH_BITS  = 6,
  localparam int IDXW      = $clog2(ADDR_BYTES + 1),
  localparam int ADDR_W    = ADDR_BYTES * DATA_W,
  localparam int HASH_N    = 1 << HASH_BITS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  rx_da_pkg::strobe_t    stb,
  input  logic [IDXW-1:0]       byteIdx,
  input  logic [DATA_W-1:0]     byteData,
  input  logic [ADDR_W-1:0]     stationAddr,
  input  logic [HASH_N-1:0]     hashTable,
  input  logic                  bcastReject,
  input  logic                  hashAll,
  output logic                  missNow
);
  import rx_da_pkg::*;

  logic [DATA_W-1:0] stationByte [ADDR_BYTES];
  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_sta
    assign stationByte[k] = stationAddr[k*DATA_W +: DATA_W];
  end

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c,
                                               input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int b = 0; b < DATA_W; b++) begin
      fb = r[CRC_W-1] ^ d[b];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  logic [CRC_W-1:0] crcQ, crcBase, crcNext;
  logic eqQ, onesQ, groupQ;
  logic eqNext, onesNext, groupNext, byteMatch;
  logic [HASH_BITS-1:0] hashIdx;

  always_comb begin
    crcBase   = stb.start ? CRC_SEED : crcQ;
    crcNext   = crcStep(crcBase, byteData);
    byteMatch = (byteIdx < IDXW'(ADDR_BYTES)) ? (byteData == stationByte[byteIdx]) : 1'b0;
    eqNext    = (stb.start ? 1'b1 : eqQ) && byteMatch;
    onesNext  = (stb.start ? 1'b1 : onesQ) && (&byteData);
    groupNext = stb.start ? byteData[0] : groupQ;
    hashIdx   = crcNext[CRC_W-1 -: HASH_BITS];
    if (onesNext)               missNow = bcastReject;
    else if (groupNext || hashAll) missNow = !hashTable[hashIdx];
    else                        missNow = !eqNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcQ   <= CRC_SEED;
      eqQ    <= 1'b0;
      onesQ  <= 1'b0;
      groupQ <= 1'b0;
    end else if (stb.take) begin
      crcQ   <= crcNext;
      eqQ    <= eqNext;
      onesQ  <= onesNext;
      groupQ <= groupNext;
    end
  end
endmodule

// File: rtl/rx_da_screen.sv
module rx_da_screen #(
  parameter int ADDR_BYTES = 6,
  parameter int DATA_W     = 8,
  parameter int HASH_BITS  = 6,
  localparam int ADDR_W    = ADDR_BYTES * DATA_W,
  localparam int HASH_N    = 1 << HASH_BITS,
  localparam int IDXW      = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic              byteSof,
  input  logic              frameEnd,
  input  logic [DATA_W-1:0] byteData,
  input  logic [ADDR_W-1:0] stationAddr,
  input  logic [HASH_N-1:0] hashTable,
  input  logic              promiscEn,
  input  logic              bcastReject,
  input  logic              hashAll,
  output logic              decValid,
  output logic              accept,
  output logic              miss
);
  rx_da_pkg::strobe_t stb;
  logic [IDXW-1:0] byteIdx;
  logic missNow;

  rx_da_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteSof(byteSof),
    .frameEnd(frameEnd), .promiscEn(promiscEn), .missNow(missNow),
    .stb(stb), .byteIdx(byteIdx), .decValid(decValid),
    .acceptQ(accept), .missQ(miss)
  );

  rx_da_path #(.ADDR_BYTES(ADDR_BYTES), .DATA_W(DATA_W), .HASH_BITS(HASH_BITS)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .byteIdx(byteIdx), .byteData(byteData),
    .stationAddr(stationAddr), .hashTable(hashTable), .bcastReject(bcastReject),
    .hashAll(hashAll), .missNow(missNow)
  );
endmodule

// File: rtl/rx_da_screen_chk.sv
module rx_da_screen_chk (
  input logic clk,
  input logic rstN,
  input logic byteValid,
  input logic byteSof,
  input logic frameEnd,
  input logic promiscEn,
  input logic decValid,
  input logic accept,
  input logic miss
);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!decValid && !$past(byteValid && byteSof)) |-> ($stable(miss) && $stable(accept)));
  // R6
  keep_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !miss) |-> accept);
  // R6
  drop_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && miss && !promiscEn) |-> !accept);
  // R2
  no_early_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteSof && !frameEnd) |=> !decValid);
  // R7
  short_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteSof && frameEnd) |=> (decValid && miss));
endmodule

bind rx_da_screen rx_da_screen_chk u_chk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteSof(byteSof),
  .frameEnd(frameEnd), .promiscEn(promiscEn), .decValid(decValid),
  .accept(accept), .miss(miss)
);

// File: tb/rx_da_screen_bench.sv
module rx_da_screen_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 1'b0, byteSof = 1'b0, frameEnd = 1'b0;
  logic [7:0] byteData = '0;
  logic [47:0] stationAddr = '0;
  logic [63:0] hashTable = '0;
  logic promiscEn = 1'b0, bcastReject = 1'b0, hashAll = 1'b0;
  logic decValid, accept, miss;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rx_da_screen u_rx_da_screen (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteSof(byteSof),
    .frameEnd(frameEnd), .byteData(byteData), .stationAddr(stationAddr),
    .hashTable(hashTable), .promiscEn(promiscEn), .bcastReject(bcastReject),
    .hashAll(hashAll), .decValid(decValid), .accept(accept), .miss(miss)
  );

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] refCrc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < 6; k++)
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[31] ^ a[8*k + b];
        c = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C11DB7;
      end
    return c;
  endfunction

  function automatic logic refMiss(input logic [47:0] a);
    if (a == 48'hFFFF_FFFF_FFFF) return bcastReject;            // R3
    if (a[0] || hashAll) return !hashTable[refCrc(a)[31:26]];    // R4
    return a != stationAddr;                                     // R5
  endfunction

  task automatic putByte(input logic [7:0] d, input logic sof, input logic eof);
    @(negedge clk);
    byteValid = 1'b1; byteData = d; byteSof = sof; frameEnd = eof;
    @(posedge clk); #1;
    byteValid = 1'b0; byteSof = 1'b0; frameEnd = 1'b0; byteData = '0;
  endtask

  // nBytes total bytes; short when < 6
  task automatic runFrame(input logic [47:0] a, input int nBytes, input int maxGap);
    logic expMiss, expAcc;
    if (nBytes < 6) begin expMiss = 1'b1; expAcc = promiscEn; end
    else begin expMiss = refMiss(a); expAcc = !expMiss || promiscEn; end
    for (int i = 0; i < nBytes; i++) begin
      int g;
      g = (maxGap > 0) ? int'($urandom_range(maxGap, 0)) : 0;
      for (int j = 0; j < g; j++) begin
        @(posedge clk); #1;
        check("R9 gap no decision", decValid, 1'b0);
      end
      putByte((i < 6) ? a[8*i +: 8] : 8'($urandom), i == 0, i == nBytes - 1);
      if (i == 5 || (nBytes < 6 && i == nBytes - 1)) begin
        check(nBytes < 6 ? "R7 short decValid" : "R2 decValid", decValid, 1'b1);
        check(nBytes < 6 ? "R7 short miss" : "R3/R4/R5 miss", miss, expMiss);
        check(nBytes < 6 ? "R7 short accept" : "R6 accept", accept, expAcc);
      end else if (i < 5) begin
        check("R2 no early decision", decValid, 1'b0);
        if (i == 0) begin
          check("R8 cleared at sof miss", miss, 1'b0);
          check("R8 cleared at sof accept", accept, 1'b0);
        end
      end else begin
        check("R2 trailing byte decValid", decValid, 1'b0);
        check("R2 trailing byte miss held", miss, expMiss);
        check("R2 trailing byte accept held", accept, expAcc);
      end
    end
    @(posedge clk); #1;
    check("R2 single-cycle strobe", decValid, 1'b0);
    check("R8 miss held", miss, expMiss);
    check("R8 accept held", accept, expAcc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [47:0] a;
    void'($urandom(32'd20240611));
    stationAddr = 48'h6655_4433_2210;
    hashTable   = {$urandom, $urandom};
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset decValid", decValid, 1'b0);
    check("R1 reset accept", accept, 1'b0);
    check("R1 reset miss", miss, 1'b0);
    @(negedge clk); rstN = 1'b1;

    // directed corners
    runFrame(stationAddr, 6, 0);                         // R5 exact hit
    a = stationAddr; a[23:16] = a[23:16] ^ 8'h04;
    runFrame(a, 8, 0);                                   // R5 one byte off
    bcastReject = 1'b0; runFrame(48'hFFFF_FFFF_FFFF, 7, 1); // R3
    bcastReject = 1'b1; runFrame(48'hFFFF_FFFF_FFFF, 6, 0); // R3
    promiscEn = 1'b1; runFrame(48'hFFFF_FFFF_FFFF, 6, 0);   // R6 kept miss
    runFrame(stationAddr, 3, 0);                         // R7 short, promisc
    promiscEn = 1'b0;
    runFrame(stationAddr, 1, 0);                         // R7 one-byte frame
    runFrame(stationAddr, 5, 2);                         // R7
    hashAll = 1'b1; runFrame(stationAddr, 6, 0);         // R4 hash overrides station
    hashAll = 1'b0;

    for (int n = 0; n < 300; n++) begin
      int kind;
      hashTable   = {$urandom, $urandom};
      promiscEn   = ($urandom_range(3, 0) == 0);
      bcastReject = $urandom_range(1, 0) == 1;
      hashAll     = 1'b0;
      kind = int'($urandom_range(4, 0));
      case (kind)
        0: a = stationAddr;
        1: begin a = stationAddr; a[8*$urandom_range(5, 0) +: 8] ^= 8'(1 << $urandom_range(7, 1)); end
        2: begin a = {$urandom, $urandom}; a[0] = 1'b1; end
        3: a = 48'hFFFF_FFFF_FFFF;
        default: begin a = {$urandom, $urandom}; a[0] = 1'b0; hashAll = 1'b1; end
      endcase
      runFrame(a, ($urandom_range(7, 0) == 0) ? int'($urandom_range(5, 1)) : int'($urandom_range(9, 6)), 2);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule